// File: doc/BRIEF.md
# Converter Result Two-Wire Slave

This block is the serial-bus face of a single-channel data converter. It oversamples the two-wire bus lines (SCL and SDA) with the system clock, finds Start, Repeated Start and Stop conditions, and runs a byte engine. The engine answers a fixed 7-bit device address and a broadcast write address. It takes one configuration byte that picks the conversion rate, and on a read it streams out a 16-bit result held by the converter. SDA is never driven high. The block only raises a pull-down enable, which the pad turns into an open-drain output.

The conversion controller beside it reports a busy flag and receives a one-cycle start request from this block. While the controller is busy, every address is refused. A new conversion is requested when the last result bit has been clocked out, or at a Stop that closes an acknowledged access. A written rate setting is held pending and only becomes the active rate when the next conversion starts.

Top module: `i2cr_result_slave`

## Requirements
- R1: After reset, sda_pull_o is 0 (SDA released), conv_start_o is 0 and rate_30hz_o is 0 (the slower-setting-off, i.e. 60 Hz, rate).
- R2: After a Start (SDA falling while SCL is high), the 7 address bits 0010100 followed by an R/W bit (1 = read, 0 = write) are acknowledged by pulling SDA low for the whole ninth SCL clock, provided conv_busy_i is 0.
- R3: While conv_busy_i is 1, a matching address is answered with SDA left released in the ninth clock (NAK), and the Stop that follows requests no conversion.
- R4: The broadcast address 1110111 with the write bit is acknowledged and the Stop that follows requests a conversion; the same address with the read bit is not acknowledged.
- R5: Any other address is not acknowledged, SDA stays released for the rest of the transaction, and the following Stop requests no conversion.
- R6: A read returns result_i as 16 bits, most significant first, as two bytes each followed by a master acknowledge slot; SDA changes only while SCL is low.
- R7: conv_start_o is a one-cycle pulse. It fires once the sixteenth read bit has been clocked out (before any Stop), and the Stop after that read requests nothing further.
- R8: After a write address ACK exactly one configuration byte is accepted and acknowledged; its last bit (bit 0) selects the 30 Hz rate when 1 and the 60 Hz rate when 0. rate_30hz_o takes the written value the cycle after the next conv_start_o pulse and not before.
- R9: A Stop straight after a write address ACK, with no data byte, requests a conversion and leaves rate_30hz_o unchanged.
- R10: A configuration written and followed by a Repeated Start and a full read stays pending until that read's sixteenth bit requests the conversion.
- R11: If the master NAKs the first read byte, SDA stays released for the rest of the transaction, and the closing Stop requests a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| result_i | input | 16 | Latest conversion result |
| conv_busy_i | input | 1 | Conversion controller is converting |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| rate_30hz_o | output | 1 | Active rate: 1 = 30 Hz, 0 = 60 Hz |

## Verification
Reads are tried with all-zero, all-one, alternating and single-edge-bit results so that bit order, byte boundaries and stuck data bits each show as a distinct wrong byte. Addressing is tried with the device address, the broadcast address in both directions, a foreign address and the device address while busy, which separates the match logic from the busy refusal. Write sequences with and without a data byte, closed by Stop or followed by a Repeated Start read, distinguish when a rate setting becomes active from when it is merely stored. A master NAK after the first byte shows whether the engine releases the line and still counts the access at Stop.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_ACK_M,
    ST_WAIT
  } xfer_st_t;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh_q;
  logic [STAGES-1:0] sda_sh_q;
  logic              scl_prev_q;
  logic              sda_prev_q;
  logic              scl_s;
  logic              sda_s;

  assign scl_s = scl_sh_q[STAGES-1];
  assign sda_s = sda_sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2cr_cfg_reg.sv
module i2cr_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_bit_i,
  input  logic conv_start_i,
  output logic rate_o
);

  logic pend_v_q, pend_v_n;
  logic pend_b_q, pend_b_n;
  logic act_q, act_n;

  always_comb begin
    pend_v_n = pend_v_q;
    pend_b_n = pend_b_q;
    act_n    = act_q;
    if (conv_start_i && pend_v_q) begin
      act_n    = pend_b_q;
      pend_v_n = 1'b0;
    end
    if (wr_i) begin
      pend_v_n = 1'b1;
      pend_b_n = wr_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_b_q <= 1'b0;
      act_q    <= 1'b0;
    end else begin
      pend_v_q <= pend_v_n;
      pend_b_q <= pend_b_n;
      act_q    <= act_n;
    end
  end

  assign rate_o = act_q;

endmodule

// File: rtl/i2cr_xfer_fsm.sv
module i2cr_xfer_fsm
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b0010100,
  parameter logic [6:0] BCAST_ADDR = 7'b1110111,
  parameter int         RES_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_s_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             conv_busy_i,
  output logic             sda_pull_o,
  output logic             conv_req_o,
  output logic             cfg_wr_o,
  output logic             cfg_bit_o
);

  localparam int NBYTES = RES_W / BYTE_BITS;
  localparam int BIW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BIW-1:0] LAST_BYTE = BIW'(NBYTES - 1);

  xfer_st_t         st_q, st_n;
  logic [2:0]       cnt_q, cnt_n;
  logic [1:0]       ph_q, ph_n;
  logic [6:0]       sh_q, sh_n;
  logic [RES_W-1:0] rd_q, rd_n;
  logic [BIW-1:0]   bidx_q, bidx_n;
  logic             rw_q, rw_n;
  logic             acc_q, acc_n;
  logic             sda_q, sda_n;
  logic             conv_q, conv_n;
  logic             wr_q, wr_n;
  logic             wbit_q, wbit_n;
  logic             hit;

  always_comb begin
    hit = ((sh_q == DEV_ADDR) || ((sh_q == BCAST_ADDR) && !sda_s_i));
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    ph_n   = ph_q;
    sh_n   = sh_q;
    rd_n   = rd_q;
    bidx_n = bidx_q;
    rw_n   = rw_q;
    acc_n  = acc_q;
    sda_n  = sda_q;
    conv_n = 1'b0;
    wr_n   = 1'b0;
    wbit_n = wbit_q;
    if (stop_i) begin
      st_n  = ST_IDLE;
      sda_n = 1'b0;
      if (acc_q) begin
        conv_n = 1'b1;
        acc_n  = 1'b0;
      end
    end else if (start_i) begin
      st_n  = ST_ADDR;
      cnt_n = 3'd0;
      sda_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[5:0], sda_s_i};
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              if (hit && !conv_busy_i) begin
                st_n = ST_ACK_A;
                ph_n = 2'd0;
                rw_n = sda_s_i;
              end else begin
                st_n = ST_WAIT;
              end
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall_i) begin
            if (ph_q == 2'd0) begin
              sda_n = 1'b1;
              ph_n  = 2'd1;
            end else begin
              acc_n = 1'b1;
              cnt_n = 3'd0;
              if (rw_q) begin
                rd_n   = result_i;
                sda_n  = ~result_i[RES_W-1];
                bidx_n = '0;
                st_n   = ST_RDATA;
              end else begin
                sda_n = 1'b0;
                st_n  = ST_WDATA;
              end
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise_i) begin
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              wr_n   = 1'b1;
              wbit_n = sda_s_i;
              st_n   = ST_ACK_W;
              ph_n   = 2'd0;
            end
          end
        end
        ST_ACK_W: begin
          if (scl_fall_i) begin
            if (ph_q == 2'd0) begin
              sda_n = 1'b1;
              ph_n  = 2'd1;
            end else begin
              sda_n = 1'b0;
              st_n  = ST_WAIT;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt_n = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              if (bidx_q == LAST_BYTE) begin
                conv_n = 1'b1;
                acc_n  = 1'b0;
                st_n   = ST_WAIT;
              end else begin
                st_n = ST_ACK_M;
                ph_n = 2'd0;
              end
            end
          end else if (scl_fall_i) begin
            rd_n  = {rd_q[RES_W-2:0], rd_q[RES_W-1]};
            sda_n = ~rd_q[RES_W-2];
          end
        end
        ST_ACK_M: begin
          if (ph_q == 2'd0) begin
            if (scl_fall_i) begin
              sda_n = 1'b0;
              ph_n  = 2'd1;
            end
          end else if (ph_q == 2'd1) begin
            if (scl_rise_i) begin
              if (!sda_s_i) ph_n = 2'd2;
              else          st_n = ST_WAIT;
            end
          end else begin
            if (scl_fall_i) begin
              rd_n   = {rd_q[RES_W-2:0], rd_q[RES_W-1]};
              sda_n  = ~rd_q[RES_W-2];
              bidx_n = bidx_q + BIW'(1);
              cnt_n  = 3'd0;
              st_n   = ST_RDATA;
            end
          end
        end
        ST_WAIT: begin
          if (scl_fall_i) sda_n = 1'b0;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= 3'd0;
      ph_q   <= 2'd0;
      sh_q   <= 7'd0;
      rd_q   <= '0;
      bidx_q <= '0;
      rw_q   <= 1'b0;
      acc_q  <= 1'b0;
      sda_q  <= 1'b0;
      conv_q <= 1'b0;
      wr_q   <= 1'b0;
      wbit_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      ph_q   <= ph_n;
      sh_q   <= sh_n;
      rd_q   <= rd_n;
      bidx_q <= bidx_n;
      rw_q   <= rw_n;
      acc_q  <= acc_n;
      sda_q  <= sda_n;
      conv_q <= conv_n;
      wr_q   <= wr_n;
      wbit_q <= wbit_n;
    end
  end

  assign sda_pull_o = sda_q;
  assign conv_req_o = conv_q;
  assign cfg_wr_o   = wr_q;
  assign cfg_bit_o  = wbit_q;

endmodule

// File: rtl/i2cr_result_slave.sv
module i2cr_result_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b0010100,
  parameter logic [6:0] BCAST_ADDR  = 7'b1110111,
  parameter int         RES_W       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [RES_W-1:0] result_i,
  input  logic             conv_busy_i,
  output logic             conv_start_o,
  output logic             rate_30hz_o
);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic cfg_wr, cfg_bit, conv_req;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2cr_xfer_fsm #(
    .DEV_ADDR   (DEV_ADDR),
    .BCAST_ADDR (BCAST_ADDR),
    .RES_W      (RES_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_s_i     (sda_s),
    .result_i    (result_i),
    .conv_busy_i (conv_busy_i),
    .sda_pull_o  (sda_pull_o),
    .conv_req_o  (conv_req),
    .cfg_wr_o    (cfg_wr),
    .cfg_bit_o   (cfg_bit)
  );

  i2cr_cfg_reg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (cfg_wr),
    .wr_bit_i     (cfg_bit),
    .conv_start_i (conv_req),
    .rate_o       (rate_30hz_o)
  );

  assign conv_start_o = conv_req;

endmodule

// File: rtl/i2cr_result_slave_chk.sv
module i2cr_result_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic conv_start_o,
  input logic rate_30hz_o
);

  // R6: the pull-down only changes while the bus clock is low
  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R7: conversion request lasts exactly one cycle
  a_r7_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  // R7: requests come from a Stop or a sixteenth-bit rising edge, both with SCL high
  a_r7_start_with_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> scl_i);

  // R8: active rate moves only the cycle after a conversion request
  a_r8_rate_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_30hz_o) |-> $past(conv_start_o));

endmodule

bind i2cr_result_slave i2cr_result_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_i        (scl_i),
  .sda_pull_o   (sda_pull_o),
  .conv_start_o (conv_start_o),
  .rate_30hz_o  (rate_30hz_o)
);

// File: tb/sim_i2cr_result_slave.sv
module sim_i2cr_result_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [6:0] DEV = 7'b0010100;
  localparam logic [6:0] BC  = 7'b1110111;
  localparam int NVEC = 6;
  // each entry: {result presented, 16-bit value the master must read}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_A5C3,
    32'h8001_8001, 32'h1234_1234, 32'h7FFE_7FFE
  };

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic [15:0] result;
  logic        busy;
  logic        sda_pull;
  logic        conv_start;
  logic        rate;
  logic        sda_bus;
  int          n_chk;
  int          n_bad;
  int          conv_cnt;

  assign sda_bus = sda_m & ~sda_pull;

  i2cr_result_slave u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_pull_o   (sda_pull),
    .result_i     (result),
    .conv_busy_i  (busy),
    .conv_start_o (conv_start),
    .rate_30hz_o  (rate)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_cnt <= 0;
    else if (conv_start) conv_cnt <= conv_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
    waitq();
  endtask

  task automatic clk_bit(input logic b, output logic got, output logic low_seen);
    sda_m = b; waitq();
    scl_m = 1'b1; waitq();
    got = sda_bus;
    low_seen = 1'b1;
    waitq();
    if (sda_bus !== got) low_seen = 1'b0;
    scl_m = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_low);
    logic g, s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], g, s);
    clk_bit(1'b1, g, s);
    ack_low = ~g & s;
  endtask

  task automatic read_byte(input logic master_nak, output logic [7:0] v);
    logic g, s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, g, s);
      v[i] = g;
    end
    clk_bit(master_nak, g, s);
  endtask

  initial begin
    logic       ack;
    logic [7:0] hi, lo;
    int         c0;
    n_chk = 0; n_bad = 0;
    scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; result = 16'h0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 sda released", {31'd0, sda_pull}, 32'd0);
    chk("R1 no start", {31'd0, conv_start}, 32'd0);
    chk("R1 rate 60Hz", {31'd0, rate}, 32'd0);

    // R2 R6 R7: read vectors
    for (int k = 0; k < NVEC; k++) begin
      result = VEC[k][31:16];
      c0 = conv_cnt;
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk("R2 read address ack", {31'd0, ack}, 32'd1);
      read_byte(1'b0, hi);
      read_byte(1'b1, lo);
      chk("R6 read data", {16'd0, hi, lo}, {16'd0, VEC[k][15:0]});
      chk("R7 start after 16th bit", conv_cnt - c0, 32'd1);
      bus_stop();
      chk("R7 no extra start on stop", conv_cnt - c0, 32'd1);
    end

    // R8 write config 1 then stop
    c0 = conv_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk("R2 write address ack", {31'd0, ack}, 32'd1);
    send_byte(8'h01, ack);
    chk("R8 config byte ack", {31'd0, ack}, 32'd1);
    chk("R8 rate pending before start", {31'd0, rate}, 32'd0);
    bus_stop();
    chk("R8 stop starts conversion", conv_cnt - c0, 32'd1);
    chk("R8 rate 30Hz after start", {31'd0, rate}, 32'd1);

    // R9 write address only then stop
    c0 = conv_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    bus_stop();
    chk("R9 start without data", conv_cnt - c0, 32'd1);
    chk("R9 rate unchanged", {31'd0, rate}, 32'd1);

    // R10 write 0, repeated start, read
    c0 = conv_cnt;
    result = 16'h5A0F;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'hFE, ack);
    bus_rstart();
    chk("R10 rate held after write", {31'd0, rate}, 32'd1);
    send_byte({DEV, 1'b1}, ack);
    chk("R10 read address ack after Sr", {31'd0, ack}, 32'd1);
    read_byte(1'b0, hi);
    chk("R10 rate held mid read", {31'd0, rate}, 32'd1);
    read_byte(1'b1, lo);
    chk("R10 read data after Sr", {16'd0, hi, lo}, 32'h5A0F);
    chk("R10 one start", conv_cnt - c0, 32'd1);
    chk("R10 rate 60Hz applied", {31'd0, rate}, 32'd0);
    bus_stop();
    chk("R10 no start on stop", conv_cnt - c0, 32'd1);

    // R4 broadcast write and read
    c0 = conv_cnt;
    bus_start();
    send_byte({BC, 1'b0}, ack);
    chk("R4 broadcast write ack", {31'd0, ack}, 32'd1);
    bus_stop();
    chk("R4 broadcast stop starts", conv_cnt - c0, 32'd1);
    bus_start();
    send_byte({BC, 1'b1}, ack);
    chk("R4 broadcast read nak", {31'd0, ack}, 32'd0);
    bus_stop();
    chk("R4 broadcast read no start", conv_cnt - c0, 32'd1);

    // R5 foreign address
    c0 = conv_cnt;
    bus_start();
    send_byte({7'b0010101, 1'b1}, ack);
    chk("R5 foreign address nak", {31'd0, ack}, 32'd0);
    read_byte(1'b1, hi);
    chk("R5 line released", {24'd0, hi}, 32'hFF);
    bus_stop();
    chk("R5 no start", conv_cnt - c0, 32'd0);

    // R3 busy refusal
    c0 = conv_cnt;
    busy = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk("R3 busy nak", {31'd0, ack}, 32'd0);
    send_byte(8'h01, ack);
    chk("R3 data ignored while busy", {31'd0, ack}, 32'd0);
    bus_stop();
    chk("R3 no start", conv_cnt - c0, 32'd0);
    chk("R3 rate unchanged", {31'd0, rate}, 32'd0);
    busy = 1'b0;

    // R11 master nak after first byte
    c0 = conv_cnt;
    result = 16'h0000;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    read_byte(1'b1, hi);
    chk("R11 first byte", {24'd0, hi}, 32'h00);
    read_byte(1'b1, lo);
    chk("R11 released after nak", {24'd0, lo}, 32'hFF);
    chk("R11 no start before stop", conv_cnt - c0, 32'd0);
    bus_stop();
    chk("R11 stop starts", conv_cnt - c0, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule